// File: doc/BRIEF.md
# Serial receive buffer with trigger interrupt

This block sits behind a serial receiver and holds incoming characters until software reads them. Each stored word is 12 bits wide. The low eight bits are the character. The upper four bits are its error flags: bit 8 framing, bit 9 parity, bit 10 line break, bit 11 overrun. A mode input selects between a 16-entry first-in first-out queue and a single holding register. The queue is also flushed whenever that mode changes.

The block reports empty and full flags, a fill count and a can-accept signal. It drives a level receive interrupt that is raised and released at an exact fill count. It also keeps a 4-bit receive-status register, which takes the error flags of the last character read. In holding-register mode, a line-break event from the receiver is turned into a stored break word.

Top module: `rxq_top`

## Requirements
- R1: After reset `isEmpty` is 1. `isFull`, `fillCount`, `rxIrq` and `rxStatus` are 0, and `canAccept` is 1.
- R2: With `fifoOn` high, words leave in the order they were accepted, across read-position wrap. `rdWord` always shows the word at the current read position.
- R3: A push is refused when `fillCount` equals the effective depth, and then `fillCount` is unchanged. `canAccept` is high exactly when `fillCount` is below the effective depth.
- R4: `isFull` is 1 exactly when `fillCount` equals the effective depth. `isEmpty` is 1 exactly when `fillCount` is 0.
- R5: With `fifoOn` low, the effective depth is 1: one word is held, and a second push is refused until it is read.
- R6: A read while empty leaves `fillCount` at 0 and the read position where it was. It still returns the stale word at that position and still loads its error bits into `rxStatus`.
- R7: `rxIrq` rises when a push brings `fillCount` to the trigger level, which is 1. It falls when a read leaves `fillCount` at 0, or on `irqAck`. Neither a flush nor a mode change alters it.
- R8: Any change of `fifoOn`, and any `flushReq`, sets the count and read position to 0, sets `isEmpty` and clears `isFull`. A push, read or break in that same cycle is ignored.
- R9: A read loads bits 11:8 of the word at the read position into `rxStatus`. `statusClear` zeroes `rxStatus`, but a read in the same cycle takes precedence.
- R10: In holding-register mode, `breakEvent` stores the word 12'h400 if there is room and sets `rxStatus` bit 2. In queue mode it has no effect.
- R11: A push and a read in the same cycle on a non-empty buffer leave `fillCount` unchanged and perform both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Store `pushWord` this cycle |
| pushWord | input | 12 | Character (7:0) with error flags (11:8) |
| popStrobe | input | 1 | Read strobe; advances the read position when non-empty |
| fifoOn | input | 1 | 1 selects 16-entry queue, 0 selects holding register |
| flushReq | input | 1 | Discard all stored words |
| breakEvent | input | 1 | Line break detected by the receiver |
| statusClear | input | 1 | Zero the receive-status register |
| irqAck | input | 1 | Clear the receive interrupt |
| rdWord | output | 12 | Word at the current read position |
| rxStatus | output | 4 | Error flags of the last word read |
| fillCount | output | 5 | Number of stored words |
| isEmpty | output | 1 | Buffer empty |
| isFull | output | 1 | Buffer at effective depth |
| canAccept | output | 1 | A push would be stored |
| rxIrq | output | 1 | Receive interrupt level |

## Verification
The bench fills the queue to 16 and pushes once more. A design that let the seventeenth word overwrite the oldest would fail the scoreboard compare when the queue is drained.

It reads while empty after the read position has wrapped, and expects the stale first word and its error bits. A design that blocked the read or kept the old status would show the wrong `rxStatus`.

It toggles the mode and pulses a flush with words stored and the interrupt high. A design that failed to flush, or that dropped the interrupt, would show a non-zero count or a low `rxIrq`.

It sends a break in each mode and performs a combined push and read. A design that honoured the break in queue mode, or that miscounted the combined push and read, would show a wrong `fillCount`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W    = 8;
  localparam int ERR_W     = 4;
  localparam int WORD_W    = DATA_W + ERR_W;
  localparam int Q_DEPTH   = 16;
  localparam int PTR_W     = $clog2(Q_DEPTH);
  localparam int CNT_W     = PTR_W + 1;
  localparam int BREAK_BIT = 10;
  localparam int TRIG_LVL  = 1;

  typedef struct packed {
    logic              wrEn;
    logic [PTR_W-1:0]  wrAddr;
    logic [WORD_W-1:0] wrData;
    logic [PTR_W-1:0]  rdAddr;
    logic              loadStatus;
    logic              clearStatus;
    logic              setBreak;
  } strobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [WORD_W-1:0] rdWord,
  output logic [ERR_W-1:0]  rxStatus
);
  localparam int BRK_IDX = BREAK_BIT - DATA_W;

  logic [WORD_W-1:0] mem [Q_DEPTH];
  logic [ERR_W-1:0]  statusQ, statusNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < Q_DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrEn) begin
      mem[strb.wrAddr] <= strb.wrData;
    end
  end

  assign rdWord = mem[strb.rdAddr];

  always_comb begin
    statusNext = statusQ;
    if (strb.loadStatus)       statusNext = rdWord[WORD_W-1:DATA_W];
    else if (strb.clearStatus) statusNext = '0;
    if (strb.setBreak)         statusNext[BRK_IDX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;
  end

  assign rxStatus = statusQ;

  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearStatus && !strb.loadStatus && !strb.setBreak |=> rxStatus == '0);
  a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStatus && !strb.setBreak |=> rxStatus == $past(rdWord[WORD_W-1:DATA_W]));
  a_r10_break_flag: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBreak |=> rxStatus[BRK_IDX]);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [WORD_W-1:0] pushWord,
  input  logic              popStrobe,
  input  logic              fifoOn,
  input  logic              flushReq,
  input  logic              breakEvent,
  input  logic              statusClear,
  input  logic              irqAck,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  fillCount,
  output logic              isEmpty,
  output logic              isFull,
  output logic              canAccept,
  output logic              rxIrq
);
  localparam logic [WORD_W-1:0] BREAK_WORD = WORD_W'(1) << BREAK_BIT;
  localparam logic [CNT_W-1:0]  TRIG_CNT   = CNT_W'(TRIG_LVL);

  logic              modeQ, emptyQ, fullQ, irqQ;
  logic [PTR_W-1:0]  rdPos;
  logic [CNT_W-1:0]  count, nextCount, depthEff;
  logic [PTR_W-1:0]  ptrMask;
  logic              flushNow, breakTake, pushEff, popEff, popSeen;

  assign depthEff  = modeQ ? CNT_W'(Q_DEPTH) : CNT_W'(1);
  assign ptrMask   = modeQ ? PTR_W'(Q_DEPTH - 1) : '0;
  assign flushNow  = flushReq | (fifoOn != modeQ);
  assign breakTake = breakEvent & ~modeQ & ~flushNow;
  assign pushEff   = ~flushNow & (pushValid | breakTake) & (count < depthEff);
  assign popSeen   = ~flushNow & popStrobe;
  assign popEff    = popSeen & (count != '0);
  assign nextCount = count + CNT_W'(pushEff) - CNT_W'(popEff);

  always_comb begin
    strb             = '0;
    strb.wrEn        = pushEff;
    strb.wrAddr      = (rdPos + count[PTR_W-1:0]) & ptrMask;
    strb.wrData      = breakTake ? BREAK_WORD : pushWord;
    strb.rdAddr      = rdPos;
    strb.loadStatus  = popSeen;
    strb.clearStatus = statusClear;
    strb.setBreak    = breakTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      count  <= '0;
      rdPos  <= '0;
      emptyQ <= 1'b1;
      fullQ  <= 1'b0;
    end else begin
      modeQ <= fifoOn;
      if (flushNow) begin
        count  <= '0;
        rdPos  <= '0;
        emptyQ <= 1'b1;
        fullQ  <= 1'b0;
      end else begin
        count <= nextCount;
        if (popEff) rdPos <= (rdPos + PTR_W'(1)) & ptrMask;
        if (pushEff || popSeen) begin
          emptyQ <= (nextCount == '0);
          fullQ  <= (nextCount == depthEff);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                         irqQ <= 1'b0;
    else if (pushEff && nextCount == TRIG_CNT)         irqQ <= 1'b1;
    else if ((popSeen && nextCount == TRIG_CNT - CNT_W'(1)) || irqAck) irqQ <= 1'b0;
  end

  assign fillCount = count;
  assign isEmpty   = emptyQ;
  assign isFull    = fullQ;
  assign canAccept = count < depthEff;
  assign rxIrq     = irqQ;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= depthEff);
  a_r4_empty_flag: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty == (fillCount == '0));
  a_r4_full_flag: assert property (@(posedge clk) disable iff (!rstN)
    isFull == (fillCount == depthEff));
  a_r5_single_slot: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> fillCount <= CNT_W'(1));
  a_r8_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> fillCount == '0 && isEmpty && !isFull);
  a_r7_flush_keeps_irq: assert property (@(posedge clk) disable iff (!rstN)
    flushNow && !irqAck |=> rxIrq == $past(rxIrq));
  a_r11_push_pop: assert property (@(posedge clk) disable iff (!rstN)
    pushEff && popEff |=> $stable(fillCount));
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [WORD_W-1:0] pushWord,
  input  logic              popStrobe,
  input  logic              fifoOn,
  input  logic              flushReq,
  input  logic              breakEvent,
  input  logic              statusClear,
  input  logic              irqAck,
  output logic [WORD_W-1:0] rdWord,
  output logic [ERR_W-1:0]  rxStatus,
  output logic [CNT_W-1:0]  fillCount,
  output logic              isEmpty,
  output logic              isFull,
  output logic              canAccept,
  output logic              rxIrq
);
  strobe_t strb;

  rxq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushWord(pushWord),
    .popStrobe(popStrobe), .fifoOn(fifoOn), .flushReq(flushReq),
    .breakEvent(breakEvent), .statusClear(statusClear), .irqAck(irqAck),
    .strb(strb), .fillCount(fillCount), .isEmpty(isEmpty), .isFull(isFull),
    .canAccept(canAccept), .rxIrq(rxIrq)
  );

  rxq_store u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .rdWord(rdWord), .rxStatus(rxStatus)
  );
endmodule

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, popStrobe = 0, fifoOn = 0, flushReq = 0;
  logic breakEvent = 0, statusClear = 0, irqAck = 0;
  logic [11:0] pushWord = '0;
  logic [11:0] rdWord;
  logic [3:0]  rxStatus;
  logic [4:0]  fillCount;
  logic isEmpty, isFull, canAccept, rxIrq;

  int total = 0, bad = 0, mCount = 0, mDepth = 1;
  bit finished = 0;
  logic [11:0] expQ[$];

  always #5 clk = ~clk;

  rxq_top u0 (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushWord(pushWord),
    .popStrobe(popStrobe), .fifoOn(fifoOn), .flushReq(flushReq),
    .breakEvent(breakEvent), .statusClear(statusClear), .irqAck(irqAck),
    .rdWord(rdWord), .rxStatus(rxStatus), .fillCount(fillCount),
    .isEmpty(isEmpty), .isFull(isFull), .canAccept(canAccept), .rxIrq(rxIrq)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard head (R2)
  always @(negedge clk) begin
    if (rstN && popStrobe && !flushReq && expQ.size() > 0) begin
      logic [11:0] e;
      e = expQ.pop_front();
      check("R2 read order", int'(rdWord), int'(e));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic doPush(logic [11:0] w);
    step();
    pushValid = 1; pushWord = w;
    if (mCount < mDepth) begin expQ.push_back(w); mCount++; end
    step();
    pushValid = 0;
  endtask

  task automatic doPop();
    step();
    popStrobe = 1;
    if (mCount > 0) mCount--;
    step();
    popStrobe = 0;
  endtask

  task automatic flags(string req, int cnt);
    check({req, " count"}, int'(fillCount), cnt);
    check({req, " empty"}, int'(isEmpty), int'(cnt == 0));
    check({req, " full"},  int'(isFull), int'(cnt == mDepth));
    check({req, " accept"}, int'(canAccept), int'(cnt < mDepth));
  endtask

  initial begin
    #150000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    flags("R1", 0);
    check("R1 irq", int'(rxIrq), 0);
    check("R1 status", int'(rxStatus), 0);

    // R5 holding-register mode
    doPush(12'h0A5);
    flags("R5", 1);
    check("R7 irq set", int'(rxIrq), 1);
    doPush(12'h0B6);
    flags("R3 refused in single mode", 1);
    doPop();
    flags("R5 after read", 0);
    check("R7 irq cleared by read", int'(rxIrq), 0);

    // R10 break in holding mode
    step(); breakEvent = 1; expQ.push_back(12'h400); mCount++;
    step(); breakEvent = 0;
    check("R10 break stored", int'(fillCount), 1);
    check("R10 break flag", int'(rxStatus), 4);
    doPop();
    check("R9 status from break word", int'(rxStatus), 4);
    step(); statusClear = 1; step(); statusClear = 0;
    check("R9 clear", int'(rxStatus), 0);

    // R8 mode change flushes, R7 irq kept
    doPush(12'h011);
    check("R7 irq before toggle", int'(rxIrq), 1);
    step(); fifoOn = 1; expQ.delete(); mCount = 0; mDepth = 16;
    step();
    flags("R8 toggle flush", 0);
    check("R7 irq kept over flush", int'(rxIrq), 1);
    step(); irqAck = 1; step(); irqAck = 0;
    check("R7 ack", int'(rxIrq), 0);

    // R2/R3 fill to 16
    for (int i = 0; i < 16; i++) doPush({i[3:0], 8'(i * 17 + 3)});
    flags("R3 full", 16);
    check("R7 irq held", int'(rxIrq), 1);
    doPush(12'hFFF);
    flags("R3 overflow refused", 16);
    for (int i = 0; i < 16; i++) doPop();
    flags("R2 drained", 0);
    check("R9 last status", int'(rxStatus), 15);
    check("R7 irq after drain", int'(rxIrq), 0);

    // R6 read while empty returns stale slot 0
    step(); popStrobe = 1;
    check("R6 stale word", int'(rdWord), 12'h003);
    step(); popStrobe = 0;
    check("R6 status from stale", int'(rxStatus), 0);
    flags("R6 count", 0);

    // R10 break ignored in queue mode
    step(); breakEvent = 1; step(); breakEvent = 0;
    flags("R10 queue mode ignore", 0);
    check("R10 no flag in queue mode", int'(rxStatus), 0);

    // R11 simultaneous push and read
    doPush(12'h1A1); doPush(12'h2B2); doPush(12'h3C3);
    step(); pushValid = 1; pushWord = 12'h4D4; popStrobe = 1; expQ.push_back(12'h4D4);
    step(); pushValid = 0; popStrobe = 0;
    flags("R11 combined", 3);
    for (int i = 0; i < 3; i++) doPop();
    flags("R11 drained", 0);

    // R8 flush request with a push in the same cycle
    doPush(12'h055); doPush(12'h066);
    step(); flushReq = 1; pushValid = 1; pushWord = 12'h077;
    step(); flushReq = 0; pushValid = 0; expQ.delete(); mCount = 0;
    flags("R8 flush", 0);
    check("R7 irq kept over flushReq", int'(rxIrq), 1);

    // R8 toggle back to single mode
    doPush(12'h088);
    step(); fifoOn = 0; expQ.delete(); mCount = 0; mDepth = 1;
    step();
    flags("R8 toggle off", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule